// File: doc/BRIEF.md
# Chip-Select Output Set/Clear Unit

This block owns a bank of general-purpose outputs that can each serve as a peripheral select line. Software configures it through a configuration word and changes output levels through a write-only action word that carries one "raise" and one "lower" bit per output. Because each pin has its own pair of bits, one write can change any subset of pins and leave the rest alone, so no read-modify-write is needed. An inversion stage per pin sits between the stored output state and the pin, so an active-high select can be driven with the same set/clear semantics as an active-low one.

A second entry point takes a select number with an assert/release flag. The number is offset by a base value to find the output index. Numbers below the base, numbers past the last output, and outputs not marked as chip-select are rejected, and a rejected command changes nothing. Asserting a select lowers its stored state and releasing it raises the stored state. With the invert bit clear, the pin is therefore active-low. The stored state and the configuration are visible on status outputs.

Top module: `cs_gpo_ctrl`

## Requirements
- R1: After reset the stored state, the configuration, every pin and the reject flag are all 0.
- R2: A configuration write takes effect on the next clock edge. Bits [2N-1:N] mark pin n (bit N+n) as a chip-select, and bits [N-1:0] invert pin n (bit n). The configuration word is readable on `cfg_o`, and bits [2N-1:N] also appear on `cs_mode_o`.
- R3: An action write with bit N+n at 1 sets stored state n at the next edge.
- R4: An action write with bit n at 1 clears stored state n at the next edge.
- R5: Outputs whose two action bits are both 0 keep their state. A cycle with no write and no command changes no state.
- R6: When the set bit and the clear bit of one output are written together, the output is cleared.
- R7: Each pin equals its stored state XOR its invert bit, and follows a change of either one in the same cycle that the change becomes visible.
- R8: An action value with all upper bits set and all lower bits clear (0xFF00 for N=8) sets every output. A configuration value of 0 removes all inversion and all chip-select marking.
- R9: A select command with a number `s` that is accepted acts on output `s - SEL_BASE`. With `sel_assert`=1 it clears that stored state, and with `sel_assert`=0 it sets it, at the next edge.
- R10: A select command is rejected if `s` < SEL_BASE, if `s` ≥ SEL_BASE+N, or if the target output is not marked as a chip-select. A rejected command leaves all state unchanged, and `sel_reject_o` is 1 for the one cycle after the command.
- R11: An action write and a select command in the same cycle are merged. A clear from either source wins over a set for the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2*N | Configuration value: chip-select marks in the upper half, invert bits in the lower half |
| act_we | input | 1 | Action write strobe |
| act_wdata | input | 2*N | Action value: set bits in the upper half, clear bits in the lower half |
| sel_valid | input | 1 | Select command strobe |
| sel_num | input | SEL_W | Select number, offset by SEL_BASE |
| sel_assert | input | 1 | 1 asserts the select (clear state), 0 releases it (set state) |
| pin_o | output | N | Output pins after inversion |
| state_o | output | N | Stored output state before inversion |
| cfg_o | output | 2*N | Current configuration word |
| cs_mode_o | output | N | Per-pin chip-select marking |
| sel_reject_o | output | 1 | One-cycle pulse after a rejected select command |

## Verification
A wrong bit in the stored state shows on `state_o`, and on `pin_o` after inversion, one edge after the write or command that caused it. A wrong set/clear priority shows only when both requests target the same output in one cycle, so the bench drives that case from the action word alone and from the action word combined with a select command. A fault in the offset or range decode would move a command to the wrong pin, or would fail to raise the reject pulse in the next cycle. To catch both, every select command is followed by a comparison of the whole state vector and the reject flag.

// File: rtl/cs_gpo_pkg.sv
package cs_gpo_pkg;

  typedef enum logic {
    SEL_RELEASE = 1'b0,
    SEL_ENGAGE  = 1'b1
  } sel_action_e;

  // true when number s maps onto one of n outputs starting at base
  function automatic logic in_window(input int unsigned s, input int unsigned base,
                                     input int unsigned n);
    return (s >= base) && (s < base + n);
  endfunction

  // merged update of a stored vector, clear has priority over set
  function automatic logic [31:0] apply_setclr(input logic [31:0] cur,
                                               input logic [31:0] setv,
                                               input logic [31:0] clrv);
    return (cur | setv) & ~clrv;
  endfunction

endpackage

// File: rtl/cs_gpo_cfg_reg.sv
module cs_gpo_cfg_reg #(
  parameter int N = 8,
  localparam int CW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end

endmodule

// File: rtl/cs_gpo_sel_decode.sv
module cs_gpo_sel_decode
  import cs_gpo_pkg::*;
#(
  parameter int N        = 8,
  parameter int SEL_W    = 8,
  parameter int SEL_BASE = 1
) (
  input  logic             sel_valid,
  input  logic [SEL_W-1:0] sel_num,
  input  logic             sel_assert,
  input  logic [N-1:0]     cs_mode,
  output logic [N-1:0]     set_vec,
  output logic [N-1:0]     clr_vec,
  output logic             in_range,
  output logic             reject
);

  logic [31:0]  sel_ext;
  logic [N-1:0] match;
  logic [N-1:0] hit;
  sel_action_e  act;

  assign sel_ext  = 32'(sel_num);
  assign in_range = in_window(sel_ext, SEL_BASE, N);
  assign act      = sel_action_e'(sel_assert);

  for (genvar i = 0; i < N; i++) begin : g_match
    assign match[i] = (sel_ext == 32'(SEL_BASE + i));
  end

  assign hit     = sel_valid ? (match & cs_mode) : '0;
  assign clr_vec = (act == SEL_ENGAGE)  ? hit : '0;
  assign set_vec = (act == SEL_RELEASE) ? hit : '0;
  assign reject  = sel_valid && !(in_range && (|(match & cs_mode)));

endmodule

// File: rtl/cs_gpo_out_stage.sv
module cs_gpo_out_stage
  import cs_gpo_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  input  logic [N-1:0] invert,
  output logic [N-1:0] state_q,
  output logic [N-1:0] pin
);

  logic [31:0] nxt;

  assign nxt = apply_setclr(32'(state_q), 32'(set_req), 32'(clr_req));

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= nxt[N-1:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_inv
    assign pin[i] = state_q[i] ^ invert[i];
  end

endmodule

// File: rtl/cs_gpo_ctrl.sv
module cs_gpo_ctrl #(
  parameter int N        = 8,
  parameter int SEL_W    = 8,
  parameter int SEL_BASE = 1,
  localparam int CW      = 2 * N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_wdata,
  input  logic             act_we,
  input  logic [CW-1:0]    act_wdata,
  input  logic             sel_valid,
  input  logic [SEL_W-1:0] sel_num,
  input  logic             sel_assert,
  output logic [N-1:0]     pin_o,
  output logic [N-1:0]     state_o,
  output logic [CW-1:0]    cfg_o,
  output logic [N-1:0]     cs_mode_o,
  output logic             sel_reject_o
);

  logic [CW-1:0] cfg_q;
  logic [N-1:0]  act_set, act_clr;
  logic [N-1:0]  cmd_set, cmd_clr;
  logic [N-1:0]  set_req, clr_req;
  logic          sel_in_range;
  logic          sel_reject_w;
  logic          reject_q;

  cs_gpo_cfg_reg #(.N(N)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  cs_gpo_sel_decode #(.N(N), .SEL_W(SEL_W), .SEL_BASE(SEL_BASE)) dec_i (
    .sel_valid(sel_valid), .sel_num(sel_num), .sel_assert(sel_assert),
    .cs_mode(cfg_q[CW-1:N]), .set_vec(cmd_set), .clr_vec(cmd_clr),
    .in_range(sel_in_range), .reject(sel_reject_w)
  );

  assign act_set = act_we ? act_wdata[CW-1:N] : '0;
  assign act_clr = act_we ? act_wdata[N-1:0]  : '0;
  assign set_req = act_set | cmd_set;
  assign clr_req = act_clr | cmd_clr;

  cs_gpo_out_stage #(.N(N)) out_i (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
    .invert(cfg_q[N-1:0]), .state_q(state_o), .pin(pin_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) reject_q <= 1'b0;
    else        reject_q <= sel_reject_w;
  end

  assign cfg_o        = cfg_q;
  assign cs_mode_o    = cfg_q[CW-1:N];
  assign sel_reject_o = reject_q;

endmodule

// File: rtl/cs_gpo_ctrl_chk.sv
module cs_gpo_ctrl_chk #(
  parameter int N = 8,
  localparam int CW = 2 * N
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [CW-1:0] cfg_wdata,
  input logic          act_we,
  input logic          sel_valid,
  input logic [N-1:0]  set_req,
  input logic [N-1:0]  clr_req,
  input logic          sel_reject_w,
  input logic [N-1:0]  state_o,
  input logic [N-1:0]  pin_o,
  input logic [CW-1:0] cfg_o,
  input logic          sel_reject_o
);

  // R2: configuration lands one edge after the write
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_o == $past(cfg_wdata));

  // R3: a state bit may rise only if a set was requested
  p_rise_needs_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (state_o & ~$past(state_o) & ~$past(set_req)) == '0);

  // R4: a state bit may fall only if a clear was requested
  p_fall_needs_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (~state_o & $past(state_o) & ~$past(clr_req)) == '0);

  // R5: no write and no command keeps the state
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_we && !sel_valid) |=> $stable(state_o));

  // R6, R11: a requested clear always wins
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (state_o & $past(clr_req)) == '0);

  // R7: with state held, pins move exactly by the change of invert bits
  p_invert_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_we && !sel_valid) |=>
      pin_o == ($past(pin_o) ^ $past(cfg_o[N-1:0]) ^ cfg_o[N-1:0]));

  // R10: a rejected command flags one cycle later
  p_reject_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reject_w |=> sel_reject_o);

  // R10: a rejected command alone leaves state untouched
  p_reject_nochg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_reject_w && !act_we) |=> $stable(state_o));

endmodule

bind cs_gpo_ctrl cs_gpo_ctrl_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .act_we(act_we), .sel_valid(sel_valid), .set_req(set_req), .clr_req(clr_req),
  .sel_reject_w(sel_reject_w), .state_o(state_o), .pin_o(pin_o), .cfg_o(cfg_o),
  .sel_reject_o(sel_reject_o)
);

// File: tb/cs_gpo_ctrl_tb_top.sv
module cs_gpo_ctrl_tb_top;

  localparam int N    = 8;
  localparam int SW   = 8;
  localparam int BASE = 1;
  localparam int CW   = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          act_we = 1'b0;
  logic [CW-1:0] act_wdata = '0;
  logic          sel_valid = 1'b0;
  logic [SW-1:0] sel_num = '0;
  logic          sel_assert = 1'b0;
  logic [N-1:0]  pin_o, state_o, cs_mode_o;
  logic [CW-1:0] cfg_o;
  logic          sel_reject_o;

  always #10 clk = ~clk;  // 50 MHz

  cs_gpo_ctrl #(.N(N), .SEL_W(SW), .SEL_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .act_we(act_we), .act_wdata(act_wdata), .sel_valid(sel_valid),
    .sel_num(sel_num), .sel_assert(sel_assert), .pin_o(pin_o),
    .state_o(state_o), .cfg_o(cfg_o), .cs_mode_o(cs_mode_o),
    .sel_reject_o(sel_reject_o)
  );

  typedef struct {
    logic [N-1:0]  st;
    logic [N-1:0]  pin;
    logic [CW-1:0] cfg;
    logic          rej;
    int            req;
  } exp_t;

  exp_t         sb_q[$];
  int           checks = 0;
  int           errors = 0;
  logic [N-1:0]  m_st  = '0;
  logic [CW-1:0] m_cfg = '0;
  bit           done = 0;

  // driver: one cycle of stimulus plus the model's expectation
  task automatic step(input logic cw, input logic [CW-1:0] cd,
                      input logic aw, input logic [CW-1:0] ad,
                      input logic sv, input int sn, input logic sa, input int req);
    logic [N-1:0] s, c;
    logic rj;
    exp_t e;
    @(negedge clk);
    cfg_we = cw; cfg_wdata = cd; act_we = aw; act_wdata = ad;
    sel_valid = sv; sel_num = SW'(sn); sel_assert = sa;
    s = aw ? ad[CW-1:N] : '0;
    c = aw ? ad[N-1:0]  : '0;
    rj = 1'b0;
    if (sv) begin
      if (sn >= BASE && sn < BASE + N && m_cfg[N + sn - BASE]) begin
        if (sa) c[sn - BASE] = 1'b1;
        else    s[sn - BASE] = 1'b1;
      end else rj = 1'b1;
    end
    m_st = (m_st | s) & ~c;
    if (cw) m_cfg = cd;
    e.st = m_st; e.cfg = m_cfg; e.pin = m_st ^ m_cfg[N-1:0]; e.rej = rj; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: compare shortly after each edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (state_o !== e.st || pin_o !== e.pin || cfg_o !== e.cfg ||
          sel_reject_o !== e.rej || cs_mode_o !== e.cfg[CW-1:N]) begin
        errors++;
        $display("FAIL R%0d: st=%h pin=%h cfg=%h rej=%b exp st=%h pin=%h cfg=%h rej=%b",
                 e.req, state_o, pin_o, cfg_o, sel_reject_o, e.st, e.pin, e.cfg, e.rej);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    checks++;
    if (state_o !== '0 || pin_o !== '0 || cfg_o !== '0 || sel_reject_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: st=%h pin=%h cfg=%h rej=%b exp all 0", state_o, pin_o, cfg_o, sel_reject_o);
    end
    rst_n = 1'b1;
    step(0, 0, 1, 16'hFF00, 0, 0, 0, 8);   // R8, R3: set all
    step(0, 0, 1, 16'h0001, 0, 0, 0, 4);   // R4: clear pin 0
    step(0, 0, 1, 16'h0000, 0, 0, 0, 5);   // R5: zero write
    step(0, 0, 0, 16'h0000, 0, 0, 0, 5);   // R5: idle
    step(1, 16'h0F0F, 0, 0, 0, 0, 0, 2);   // R2: configure
    step(0, 0, 0, 0, 0, 0, 0, 7);          // R7: inverted pins
    step(0, 0, 1, 16'h0202, 0, 0, 0, 6);   // R6: set and clear together
    step(0, 0, 1, 16'h0200, 0, 0, 0, 3);   // R3: set pin 1
    step(0, 0, 0, 0, 1, 1, 1, 9);          // R9: assert sel 1 -> pin 0
    step(0, 0, 0, 0, 1, 4, 0, 9);          // R9: release sel 4 -> pin 3
    step(0, 0, 0, 0, 1, 4, 1, 9);          // R9: assert sel 4
    step(0, 0, 0, 0, 1, 0, 1, 10);         // R10: below base
    step(0, 0, 0, 0, 1, 9, 0, 10);         // R10: past last output
    step(0, 0, 0, 0, 1, 6, 0, 10);         // R10: not a chip-select
    step(0, 0, 0, 0, 0, 0, 0, 10);         // R10: pulse ends
    step(0, 0, 1, 16'h0400, 1, 2, 1, 11);  // R11: cmd clear pin 1, act set pin 2
    step(0, 0, 1, 16'h0200, 1, 2, 1, 11);  // R11: cmd clear beats act set
    step(0, 0, 1, 16'h0001, 1, 1, 0, 11);  // R11: act clear beats cmd set
    step(1, 16'h00A5, 0, 0, 0, 0, 0, 7);   // R7: change invert only
    step(0, 0, 0, 0, 0, 0, 0, 7);          // R7
    for (int i = 0; i < N; i++) begin
      step(0, 0, 1, CW'(1) << (N + i), 0, 0, 0, 3);   // R3: walking set
      step(0, 0, 1, CW'(1) << i, 0, 0, 0, 4);         // R4: walking clear
    end
    step(1, 16'h0000, 1, 16'hFF00, 0, 0, 0, 8);      // R8: all high, normal mode
    step(0, 0, 0, 0, 1, 3, 1, 10);                   // R10: nothing marked
    step(0, 0, 0, 0, 0, 0, 0, 8);
    step(0, 0, 0, 0, 0, 0, 0, 8);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule